// File: doc/BRIEF.md
# Per-Field Converter Range Excursion Histogram

This block gathers range statistics for a video gain-control loop. Three converter channels, one luma (Y) and two chroma (U, V), each report a graded 2-bit overflow severity on every pixel. The two chroma channels also raise an underflow flag. A channel selector picks which of the three is watched. Over one field, the block counts how many valid samples fell into each of the three overflow grades. At the next field-start pulse it freezes those counts in read registers for a host and starts the next field from zero.

The chroma channels can leave their range in either direction. For them, an underflow is added to the mildest overflow bin, so a gain controller reads that bin as plain out-of-range information. A selector change waits for the next field start, so one field never mixes two channels. Counters stop at their maximum value and do not wrap. A host reads any bin through a small address/data port with no handshake.

Top module: `range_hist`

## Requirements
- R1: After reset, every read register returns zero and every live counter is zero.
- R2: Each sample carries an overflow code. Code 0 means in range and increments no bin. Codes 1, 2 and 3 (about 1 dB, 1 to 2 dB, 2 to 3 dB) increment the bins read at addresses 0, 1 and 2 respectively. Each bin grows by at most one per sample.
- R3: A sample counts only in a cycle where `sample_valid` is high.
- R4: The selector is encoded 0 = Y, 1 = U, 2 = V and 3 = nothing monitored. A new selector value is taken at a field-start pulse and is used for the sample in that same cycle. A change between pulses has no effect until the next pulse.
- R5: With U or V monitored, that channel's underflow flag increments the address-0 bin, at most once per sample even when code 1 is also present. Underflow flags have no effect while Y is monitored, and the other chroma channel's flag never counts.
- R6: On a field-start pulse, the three live counts are copied into the read registers. Between pulses the read registers hold their values.
- R7: In the cycle of a field-start pulse the live counters restart. A sample in that same cycle counts toward the new field.
- R8: A counter that has reached 2^CNT_W-1 stays there for the rest of the field (CNT_W defaults to 16).
- R9: `rd_data` shows the read register chosen by `rd_addr` (0, 1, 2) in the same cycle, and reads as zero for address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (16 MHz sample rate) |
| rst_n | input | 1 | Active-low synchronous reset |
| field_start | input | 1 | One-cycle pulse at the start of each field |
| sample_valid | input | 1 | High for one cycle per pixel |
| chan_sel | input | 2 | Channel to monitor: 0 Y, 1 U, 2 V, 3 none |
| ovf_y | input | 2 | Luma overflow code |
| ovf_u | input | 2 | U overflow code |
| ovf_v | input | 2 | V overflow code |
| unf_u | input | 1 | U underflow flag |
| unf_v | input | 1 | V underflow flag |
| rd_addr | input | 2 | Read register select |
| rd_data | output | CNT_W | Selected frozen bin count |

## Verification
The bench builds the block with CNT_W = 4. This brings saturation within reach in about twenty samples, so one field can drive one bin past its ceiling, stop a second bin exactly at it and hold a third just below it. The rest of the behaviour does not depend on the width, so the narrow counters still cover selector timing, underflow merging and the field-start handover. Runs at the default width are covered by the assertions.

// File: rtl/range_hist_pkg.sv
package range_hist_pkg;

  localparam int unsigned NBINS  = 3;
  localparam int unsigned CODE_W = 2;

  typedef enum logic [1:0] {
    SEL_Y    = 2'd0,
    SEL_U    = 2'd1,
    SEL_V    = 2'd2,
    SEL_NONE = 2'd3
  } chan_sel_e;

  // Map one sample onto the bins it hits: grade k lands in bin k-1,
  // an underflow is folded into the mildest bin.
  function automatic logic [NBINS-1:0] bin_hits(input logic valid,
                                                input logic [CODE_W-1:0] code,
                                                input logic unf);
    logic [NBINS-1:0] h;
    h = '0;
    if (valid) begin
      for (int k = 1; k <= NBINS; k++) begin
        if (int'(code) == k) h[k-1] = 1'b1;
      end
      if (unf) h[0] = 1'b1;
    end
    return h;
  endfunction

endpackage

// File: rtl/range_hist_sel.sv
module range_hist_sel
  import range_hist_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              field_start,
  input  logic              sample_valid,
  input  logic [1:0]        chan_sel,
  input  logic [CODE_W-1:0] ovf_y,
  input  logic [CODE_W-1:0] ovf_u,
  input  logic [CODE_W-1:0] ovf_v,
  input  logic              unf_u,
  input  logic              unf_v,
  output logic [NBINS-1:0]  bin_hit,
  output logic [1:0]        active_sel
);

  chan_sel_e        sel_q;
  chan_sel_e        eff_sel;
  logic [CODE_W-1:0] mon_code;
  logic              mon_unf;

  // The selector is sampled only at a field boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)           sel_q <= SEL_Y;
    else if (field_start) sel_q <= chan_sel_e'(chan_sel);
  end

  // A sample coinciding with the boundary already belongs to the new field.
  assign eff_sel = field_start ? chan_sel_e'(chan_sel) : sel_q;

  always_comb begin
    mon_code = '0;
    mon_unf  = 1'b0;
    case (eff_sel)
      SEL_Y: mon_code = ovf_y;
      SEL_U: begin mon_code = ovf_u; mon_unf = unf_u; end
      SEL_V: begin mon_code = ovf_v; mon_unf = unf_v; end
      default: begin mon_code = '0; mon_unf = 1'b0; end
    endcase
  end

  assign bin_hit    = bin_hits(sample_valid, mon_code, mon_unf);
  assign active_sel = sel_q;

  assert_sel_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> active_sel == $past(chan_sel));
  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(active_sel));
  assert_idle_nohit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> bin_hit == '0);
  assert_luma_unf_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && active_sel == 2'd0 && ovf_y == '0) |-> bin_hit == '0);
  assert_none_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && active_sel == 2'd3) |-> bin_hit == '0);

endmodule

// File: rtl/range_hist_bin.sv
module range_hist_bin #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  // Next live count: restart on a boundary, otherwise saturating increment.
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] cur,
                                                  input logic restart,
                                                  input logic inc);
    if (restart)                  return inc ? CNT_W'(1) : '0;
    else if (inc && cur != CNT_MAX) return cur + CNT_W'(1);
    else                          return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, field_start, hit);
  end

  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && count == CNT_MAX) |=> count == CNT_MAX);
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> (count == $past(count) || count == $past(count) + CNT_W'(1)));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    field_start |=> count <= CNT_W'(1));

endmodule

// File: rtl/range_hist_snap.sv
module range_hist_snap
  import range_hist_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        field_start,
  input  logic [NBINS-1:0][CNT_W-1:0] live,
  input  logic [1:0]                  rd_addr,
  output logic [CNT_W-1:0]            rd_data
);

  logic [NBINS-1:0][CNT_W-1:0] frozen;

  for (genvar b = 0; b < NBINS; b++) begin : g_frz
    always_ff @(posedge clk) begin
      if (!rst_n)           frozen[b] <= '0;
      else if (field_start) frozen[b] <= live[b];
    end

    assert_snap_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |=> frozen[b] == $past(live[b]));
    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !field_start |=> $stable(frozen[b]));
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBINS; b++) begin
      if (int'(rd_addr) == b) rd_data = frozen[b];
    end
  end

endmodule

// File: rtl/range_hist.sv
module range_hist
  import range_hist_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             sample_valid,
  input  logic [1:0]       chan_sel,
  input  logic [1:0]       ovf_y,
  input  logic [1:0]       ovf_u,
  input  logic [1:0]       ovf_v,
  input  logic             unf_u,
  input  logic             unf_v,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data
);

  logic [NBINS-1:0]            bin_hit;
  logic [1:0]                  active_sel;
  logic [NBINS-1:0][CNT_W-1:0] live;

  range_hist_sel u_sel (
    .clk          (clk),
    .rst_n        (rst_n),
    .field_start  (field_start),
    .sample_valid (sample_valid),
    .chan_sel     (chan_sel),
    .ovf_y        (ovf_y),
    .ovf_u        (ovf_u),
    .ovf_v        (ovf_v),
    .unf_u        (unf_u),
    .unf_v        (unf_v),
    .bin_hit      (bin_hit),
    .active_sel   (active_sel)
  );

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    range_hist_bin #(.CNT_W(CNT_W)) u_bin (
      .clk         (clk),
      .rst_n       (rst_n),
      .field_start (field_start),
      .hit         (bin_hit[b]),
      .count       (live[b])
    );
  end

  range_hist_snap #(.CNT_W(CNT_W)) u_snap (
    .clk         (clk),
    .rst_n       (rst_n),
    .field_start (field_start),
    .live        (live),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (live == '0));
  assert_bin_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_start && !sample_valid) |=> $stable(live));

endmodule

// File: tb/range_hist_test.sv
module range_hist_test;

  localparam int unsigned CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             field_start = 1'b0;
  logic             sample_valid = 1'b0;
  logic [1:0]       chan_sel = 2'd0;
  logic [1:0]       ovf_y = 2'd0, ovf_u = 2'd0, ovf_v = 2'd0;
  logic             unf_u = 1'b0, unf_v = 1'b0;
  logic [1:0]       rd_addr = 2'd0;
  logic [CNT_W-1:0] rd_data;

  int total = 0;
  int bad   = 0;

  range_hist #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .sample_valid(sample_valid), .chan_sel(chan_sel),
    .ovf_y(ovf_y), .ovf_u(ovf_u), .ovf_v(ovf_v),
    .unf_u(unf_u), .unf_v(unf_v),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always #5 clk = ~clk;

  task automatic step(input logic fs, input logic vld, input logic [1:0] sel,
                      input logic [1:0] y, input logic [1:0] u, input logic [1:0] v,
                      input logic uu, input logic uv);
    @(negedge clk);
    field_start = fs; sample_valid = vld; chan_sel = sel;
    ovf_y = y; ovf_u = u; ovf_v = v; unf_u = uu; unf_v = uv;
    @(posedge clk);
  endtask

  task automatic boundary(input logic [1:0] sel);
    step(1'b1, 1'b0, sel, 2'd0, 2'd0, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic check_bins(input int e0, input int e1, input int e2, input string tag);
    int exp_v;
    @(negedge clk);
    field_start = 1'b0; sample_valid = 1'b0;
    for (int a = 0; a < 4; a++) begin
      exp_v = (a == 0) ? e0 : (a == 1) ? e1 : (a == 2) ? e2 : 0;
      rd_addr = 2'(a);
      #1;
      total++;
      if (int'(rd_data) != exp_v) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, rd_data, exp_v);
      end
    end
  endtask

  task automatic t_reset();
    check_bins(0, 0, 0, "R1 R9 reset");
  endtask

  task automatic t_codes();
    logic [1:0] seq [8] = '{2'd1, 2'd1, 2'd2, 2'd3, 2'd3, 2'd3, 2'd0, 2'd0};
    boundary(2'd0);
    foreach (seq[i]) step(1'b0, 1'b1, 2'd0, seq[i], 2'd0, 2'd0, 1'b0, 1'b0);
    boundary(2'd0);
    check_bins(2, 1, 3, "R2 R6 grades");
  endtask

  task automatic t_valid();
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 2'd0, 2'd3, 2'd2, 2'd1, 1'b1, 1'b1);
    boundary(2'd0);
    check_bins(0, 0, 0, "R3 invalid samples");
  endtask

  task automatic t_under();
    boundary(2'd1);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 2'd1, 2'd0, 2'd1, 2'd0, 1'b1, 1'b0);
    step(1'b0, 1'b1, 2'd1, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 2'd1, 2'd3, 2'd0, 2'd0, 1'b0, 1'b1);
    boundary(2'd2);
    check_bins(4, 1, 0, "R5 U underflow merge");
    step(1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 2'd3, 1'b0, 1'b1);
    step(1'b0, 1'b1, 2'd2, 2'd0, 2'd0, 2'd0, 1'b1, 1'b0);
    boundary(2'd0);
    check_bins(1, 0, 1, "R5 V underflow merge");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'd0, 2'd0, 2'd3, 2'd3, 1'b1, 1'b1);
    boundary(2'd0);
    check_bins(0, 0, 0, "R5 luma ignores underflow");
  endtask

  task automatic t_sel();
    for (int i = 0; i < 2; i++) step(1'b0, 1'b1, 2'd2, 2'd1, 2'd0, 2'd3, 1'b0, 1'b0);
    step(1'b1, 1'b1, 2'd2, 2'd1, 2'd0, 2'd2, 1'b0, 1'b0);
    check_bins(2, 0, 0, "R4 late selector change");
    step(1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd3, 1'b0, 1'b0);
    boundary(2'd3);
    check_bins(0, 1, 1, "R4 R7 boundary sample in new field");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 2'd3, 2'd3, 2'd3, 2'd3, 1'b1, 1'b1);
    boundary(2'd0);
    check_bins(0, 0, 0, "R4 nothing monitored");
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, 2'd0, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
    for (int i = 0; i < 14; i++) step(1'b0, 1'b1, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0);
    boundary(2'd0);
    check_bins(15, 14, 15, "R8 saturation");
  endtask

  task automatic t_hold();
    step(1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
    boundary(2'd0);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 2'd0, 2'd2, 2'd0, 2'd0, 1'b0, 1'b0);
    check_bins(1, 0, 0, "R6 frozen mid-field");
    boundary(2'd0);
    check_bins(0, 5, 0, "R6 next snapshot");
    boundary(2'd0);
    check_bins(0, 0, 0, "R7 counters restarted");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_codes();
    t_valid();
    t_under();
    t_sel();
    t_sat();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule